// File: doc/BRIEF.md
# Dual-Mode Link Status LED Driver

This block drives a single indicator LED from link-state flags that a separate link controller supplies. A mode-select input picks what the LED means. In the duplex/collision mode the LED is lit steadily while the link runs full duplex. In half duplex it blinks at a set rate while collisions are being seen, and it stays dark otherwise. In the 10 Mb/s mode the LED is lit steadily only while the link is up at 10 Mb/s.

The blink rate comes from dividing the system clock. A collision is a single-cycle pulse, so a hold timer stretches it into a visible burst of blinking. Every new pulse reloads the timer, and blinking stops once a full hold window passes with no further pulses. The LED is driven from a register. The polarity of the pin is a parameter, so the block can drive either an active-high or an active-low LED.

Top module: `led_status_drv`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `led_o` sits at its off level, and reset discards any collision hold in progress, so no blinking follows reset until a new pulse arrives.
- R2: `mode_sel` = 0 selects the duplex/collision meaning, and `mode_sel` = 1 selects the 10 Mb/s link meaning. A change takes effect on the next clock edge.
- R3: With `mode_sel` = 0 and `full_dup` = 1, the LED is on steadily from the first edge after the inputs are applied, and collision pulses do not disturb it.
- R4: With `mode_sel` = 0 and `full_dup` = 0, the LED is off when no collision pulse has arrived in the last `HOLD_CYC` cycles.
- R5: With `mode_sel` = 0 and `full_dup` = 0, a collision pulse sampled at edge 1 turns the LED on from edge 2. The LED then alternates HALF cycles on and HALF cycles off, starting with the on phase, where HALF = `CLK_HZ`/(2·`BLINK_HZ`) (a 50% duty blink at `BLINK_HZ`).
- R6: Each collision pulse reloads the hold timer without restarting the blink phase. The LED is forced off from edge `HOLD_CYC`+2, counted from the last pulse sampled at edge 1.
- R7: With `mode_sel` = 1, the LED is on exactly when `link_up` = 1 and `spd_100` = 0, and collision pulses have no effect.
- R8: The pin level is the LED state XOR `ACTIVE_LOW`, so an active-low build drives 1 when the LED is dark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = duplex/collision meaning, 1 = 10 Mb/s link meaning |
| full_dup | input | 1 | Link is running full duplex |
| link_up | input | 1 | Link is established |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| coll_pulse | input | 1 | One-cycle pulse per collision seen |
| led_o | output | 1 | LED drive pin, polarity set by ACTIVE_LOW |

## Verification
The hardest situation to reach is a retriggered collision burst. In that case a second pulse lands partway through the hold window, so the hold is extended while the blink phase carries on from the first pulse. The bench shrinks the divider and the hold through parameters so that the whole burst fits in a few dozen cycles. It fires a pulse and fires a second one twenty cycles later. It then compares the LED every cycle against an on/off pattern computed from the first pulse, with an end point computed from the second pulse. Reset during an active hold is reached the same way, with reset asserted a few cycles after a pulse.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic {
    LED_MODE_DUPCOL = 1'b0,
    LED_MODE_LINK10 = 1'b1
  } led_mode_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction
endpackage

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int unsigned HALF_CYC = 1_250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic phase_o
);
  localparam int unsigned CW = led_pkg::cnt_width(HALF_CYC);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  // Idle keeps the divider parked at the start of an on phase.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST); // R5
  AST_IDLE_PHASE_ON: assert property (@(posedge clk) disable iff (rst) !en |=> phase_q); // R5
  AST_PHASE_MID_STABLE: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q != '0) |-> $stable(phase_q)); // R5
endmodule

// File: rtl/led_coll_stretch.sv
module led_coll_stretch #(
  parameter int unsigned HOLD_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic active_o
);
  localparam int unsigned HW = led_pkg::cnt_width(HOLD_CYC);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (pulse_i) begin
      hold_q <= LOAD;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign active_o = (hold_q != '0);

  initial begin
    assert (HOLD_CYC >= 1);
  end

  AST_PULSE_ARMS: assert property (@(posedge clk) disable iff (rst) pulse_i |=> active_o); // R6
  AST_QUIET_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
    (!pulse_i && !active_o) |=> !active_o); // R4
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst) hold_q <= LOAD); // R6
endmodule

// File: rtl/led_mode_mux.sv
module led_mode_mux #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic full_dup,
  input  logic link_up,
  input  logic spd_100,
  input  logic coll_act,
  input  logic blink_ph,
  output logic led_o
);
  import led_pkg::*;

  localparam logic OFF_LVL = ACTIVE_LOW;

  led_mode_e mode;
  logic      lit_d;
  logic      lit_q;

  assign mode = led_mode_e'(mode_sel);

  always_comb begin
    unique case (mode)
      LED_MODE_DUPCOL: lit_d = full_dup | (coll_act & blink_ph);
      LED_MODE_LINK10: lit_d = link_up & ~spd_100;
      default:         lit_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lit_q <= 1'b0;
    else     lit_q <= lit_d;
  end

  assign led_o = lit_q ^ ACTIVE_LOW;

  AST_RESET_DARK: assert property (@(posedge clk) rst |=> led_o == OFF_LVL); // R1
  AST_FD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!mode_sel && full_dup) |=> lit_q); // R3
  AST_HD_QUIET_DARK: assert property (@(posedge clk) disable iff (rst)
    (!mode_sel && !full_dup && !coll_act) |=> !lit_q); // R4
  AST_LINK10_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_sel && link_up && !spd_100) |=> lit_q); // R7
  AST_LINK10_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_sel && !(link_up && !spd_100)) |=> !lit_q); // R7
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned BLINK_HZ   = 20,
  parameter int unsigned HOLD_CYC   = 5_000_000,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic full_dup,
  input  logic link_up,
  input  logic spd_100,
  input  logic coll_pulse,
  output logic led_o
);
  localparam int unsigned HALF_RAW = CLK_HZ / (2 * BLINK_HZ);
  localparam int unsigned HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic coll_act;
  logic blink_ph;

  led_coll_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk(clk), .rst(rst), .pulse_i(coll_pulse), .active_o(coll_act)
  );

  led_blink_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst(rst), .en(coll_act), .phase_o(blink_ph)
  );

  led_mode_mux #(.ACTIVE_LOW(ACTIVE_LOW)) u_mux (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .full_dup(full_dup),
    .link_up(link_up), .spd_100(spd_100), .coll_act(coll_act),
    .blink_ph(blink_ph), .led_o(led_o)
  );

  AST_COLL_MODE2_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mode_sel && spd_100) |=> led_o == ACTIVE_LOW); // R7
endmodule

// File: tb/led_status_drv_bench.sv
module led_status_drv_bench;
  localparam int unsigned CLK_HZ = 200;
  localparam int unsigned BLINK_HZ = 20;
  localparam int unsigned HALF = CLK_HZ / (2 * BLINK_HZ);
  localparam int unsigned HOLD = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0, full_dup = 1'b0, link_up = 1'b0, spd_100 = 1'b0, coll_pulse = 1'b0;
  logic led_hi, led_lo;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  led_status_drv #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ), .HOLD_CYC(HOLD), .ACTIVE_LOW(1'b0))
    u_led_status_drv (.clk(clk), .rst(rst), .mode_sel(mode_sel), .full_dup(full_dup),
      .link_up(link_up), .spd_100(spd_100), .coll_pulse(coll_pulse), .led_o(led_hi));

  led_status_drv #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ), .HOLD_CYC(HOLD), .ACTIVE_LOW(1'b1))
    u_led_status_drv_n (.clk(clk), .rst(rst), .mode_sel(mode_sel), .full_dup(full_dup),
      .link_up(link_up), .spd_100(spd_100), .coll_pulse(coll_pulse), .led_o(led_lo));

  // {mode_sel, full_dup, link_up, spd_100, expected lit}
  localparam logic [4:0] VEC [10] = '{
    5'b0_1_1_1_1,  // R3 full duplex, 100M
    5'b0_1_0_0_1,  // R3 full duplex, link flag low
    5'b0_0_1_0_0,  // R4 half duplex quiet
    5'b0_0_1_1_0,  // R4
    5'b1_0_1_0_1,  // R7 10M link up
    5'b1_1_1_0_1,  // R7 duplex irrelevant
    5'b1_0_1_1_0,  // R7 100M
    5'b1_1_0_0_0,  // R7 link down
    5'b1_1_1_1_0,  // R2 mode 1 ignores full duplex
    5'b0_1_1_1_1   // R2 back to mode 0
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    total++;
    if (led_hi !== exp || led_lo !== ~exp) begin
      bad++;
      $display("FAIL %s: led_hi=%b led_lo=%b expected %b/%b", req, led_hi, led_lo, exp, ~exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: cycles=%0d expected <= 100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1, R8: reset level on both polarities
    step(); step();
    check(1'b0, "R1");
    rst = 1'b0;

    foreach (VEC[i]) begin
      {mode_sel, full_dup, link_up, spd_100} = VEC[i][4:1];
      step();
      check(VEC[i][0], "R2/R3/R4/R7");
    end

    // R5, R6: burst with a retrigger at k=20; blink referenced to first pulse
    mode_sel = 1'b0; full_dup = 1'b0; link_up = 1'b1; spd_100 = 1'b0;
    step();
    check(1'b0, "R4");
    coll_pulse = 1'b1;
    for (int k = 1; k <= 75; k++) begin
      step();
      coll_pulse = (k == 20);
      check((k >= 2 && k <= 21 + HOLD) && (((k - 2) / HALF) % 2 == 0),
            (k > 21 + HOLD - 2) ? "R6" : "R5");
    end

    // R3: collisions do not disturb full duplex
    full_dup = 1'b1;
    coll_pulse = 1'b1;
    for (int k = 1; k <= 25; k++) begin
      step();
      coll_pulse = (k == 7);
      check(1'b1, "R3");
    end
    coll_pulse = 1'b0;

    // R7: collisions ignored in mode 1 at 100M
    mode_sel = 1'b1; spd_100 = 1'b1; full_dup = 1'b0;
    coll_pulse = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      step();
      coll_pulse = 1'b0;
      check(1'b0, "R7");
    end
    // R2: switch to mode 0 while hold may be live -> must be dark after hold expiry
    for (int k = 1; k <= HOLD; k++) step();
    mode_sel = 1'b0;
    step();
    check(1'b0, "R4");

    // R1: reset during an active hold clears it
    coll_pulse = 1'b1;
    step();
    coll_pulse = 1'b0;
    step(); step();
    check(1'b1, "R5");
    rst = 1'b1;
    step();
    check(1'b0, "R1");
    rst = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      step();
      check(1'b0, "R1");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule